// File: doc/BRIEF.md
# Microcoded Memory Signal Sequencer

This block drives the control strobes of an external memory or peripheral from a small RAM of control words, not from a fixed state machine. Each kind of transaction starts at its own fixed entry address in the RAM. From there the sequencer steps through the words one clock at a time. Each word gives the chip-select and byte-select levels for the four quarter phases of the cycle and the levels of five general-purpose outputs for each half cycle. The same word carries sequencing controls: repeat the word, mark the start or end of a loop, advance the beat address, acknowledge a data beat, and end the routine.

Software loads the control words through a simple write port while the block is idle. A requester starts single or burst reads and writes with a one-cycle request pulse. A refresh request and an exception request start their own routines. All requests are taken only between routines. An optional wait input, whose active level is programmable, stalls the sequencer on the current word. Because it shares a pin with general-purpose output 4, that output is released when wait mode is on.

Top module: `useq_top`

## Requirements
- R1: When idle, a request pulse starts a routine, and the cycle after the pulse presents the word at the entry address: single read 0x00, burst read 0x08, single write 0x18, burst write 0x20, refresh 0x30, exception 0x3C.
- R2: Control word layout, bit 0 first: [3:0] chip-select levels with bit i for quarter phase i+1, [7:4] byte-select levels in the same order, [12:8] general-purpose outputs 1–5 for phases 1–2, [17:13] the same outputs for phases 3–4, [19:18] repeat count, [20] loop mark, [21] beat-address step, [22] acknowledge, [23] last. While a routine runs, `cs_ph` and `bs_ph` show the current word's fields. While idle, they are all ones, both general-purpose buses are zero, and `ta` is low.
- R3: `gpo_lo` and `gpo_hi` carry the two half-cycle levels of each general-purpose output, with bit k for output k+1, taken from the current word.
- R4: A word with repeat count r is presented for r+1 consecutive cycles, when no stall occurs.
- R5: The first loop-marked word opens a loop and the next loop-marked word closes it. At the closing word, the sequencer jumps back to the opening word until the body has run the loop count plus one times. The count is `cfg_rd_loop` for read, refresh and exception routines, and `cfg_wr_loop` for write routines.
- R6: `beat_addr` is loaded from `req_addr` when an access starts, and with 0 when a refresh or exception starts. It increments by one, modulo 32, after the final cycle of each word whose step bit is set.
- R7: `ta` is high for exactly one cycle per acknowledge-flagged word: its final, unstalled cycle.
- R8: After the final cycle of a word with the last bit set, `busy` falls and the block is idle in the next cycle.
- R9: With `cfg_wait_en` set and `wait_in` equal to `cfg_wait_pol`, the sequencer holds its current word, repeat count and beat address, and all outputs keep their levels. With `cfg_wait_en` clear, `wait_in` has no effect.
- R10: With `cfg_wait_en` set, bit 3 (output 4) of both `gpo_lo` and `gpo_hi` is forced to 0.
- R11: When several requests arrive in the same idle cycle, exception wins over refresh, and refresh wins over an access. The requests that lose are dropped.
- R12: Request, refresh and exception pulses that arrive while a routine runs are ignored. No routine follows the current one.
- R13: A write on the host port stores `prog_wdata` at `prog_addr`, and the next routine that reaches that address uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Host write strobe for the control RAM |
| prog_addr | input | 6 | Host write address |
| prog_wdata | input | 24 | Control word to store |
| req_valid | input | 1 | Access request pulse |
| req_write | input | 1 | Access is a write |
| req_burst | input | 1 | Access is a burst |
| req_addr | input | 5 | Starting beat address |
| ref_req | input | 1 | Refresh request pulse |
| exc_req | input | 1 | Exception request pulse |
| cfg_rd_loop | input | 4 | Loop count for read, refresh and exception routines |
| cfg_wr_loop | input | 4 | Loop count for write routines |
| cfg_wait_en | input | 1 | Shared pin works as the wait input |
| cfg_wait_pol | input | 1 | Level of `wait_in` that means wait |
| wait_in | input | 1 | Wait input |
| cs_ph | output | 4 | Chip-select level for each quarter phase |
| bs_ph | output | 4 | Byte-select level for each quarter phase |
| gpo_lo | output | 5 | General-purpose output levels, phases 1–2 |
| gpo_hi | output | 5 | General-purpose output levels, phases 3–4 |
| ta | output | 1 | Data beat acknowledge |
| busy | output | 1 | A routine is running |
| beat_addr | output | 5 | Low beat address |

## Verification
The bench sweeps both loop counts from 0 to 3 on the burst read and burst write routines, with the other count set to 3. A design that picks the wrong count, runs the body one time too few or too many, or fails to wrap the beat address from 31 to 0 gets the trace length, the acknowledge count or the final address wrong. The bench also sweeps stall lengths from 0 to 4 under both wait polarities, and a design that advances, or acknowledges, during a stall shows the wrong trace length. Finally, it fires requests together and in the middle of a routine, which catches a wrong priority order and any pulse that is remembered rather than dropped.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W = 6;
    localparam int WORD_W = 24;

    localparam logic [ADDR_W-1:0] ENT_SRD = 6'h00;
    localparam logic [ADDR_W-1:0] ENT_BRD = 6'h08;
    localparam logic [ADDR_W-1:0] ENT_SWR = 6'h18;
    localparam logic [ADDR_W-1:0] ENT_BWR = 6'h20;
    localparam logic [ADDR_W-1:0] ENT_REF = 6'h30;
    localparam logic [ADDR_W-1:0] ENT_EXC = 6'h3C;

    typedef struct packed {
        logic       last;
        logic       ack;
        logic       step;
        logic       loop;
        logic [1:0] redo;
        logic [4:0] gpo_hi;
        logic [4:0] gpo_lo;
        logic [3:0] bs;
        logic [3:0] cs;
    } ctl_word_t;

endpackage

// File: rtl/useq_ram.sv
module useq_ram #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/useq_pinmux.sv
module useq_pinmux #(
    parameter int GPO_N   = 5,
    parameter int WAIT_IX = 3
) (
    input  logic             running,
    input  logic [3:0]       w_cs,
    input  logic [3:0]       w_bs,
    input  logic [GPO_N-1:0] w_lo,
    input  logic [GPO_N-1:0] w_hi,
    input  logic             cfg_wait_en,
    input  logic             cfg_wait_pol,
    input  logic             wait_in,
    output logic             stall,
    output logic [3:0]       cs_ph,
    output logic [3:0]       bs_ph,
    output logic [GPO_N-1:0] gpo_lo,
    output logic [GPO_N-1:0] gpo_hi
);
    always_comb begin
        stall = running && cfg_wait_en && (wait_in == cfg_wait_pol);
        cs_ph = running ? w_cs : '1;
        bs_ph = running ? w_bs : '1;
    end

    for (genvar k = 0; k < GPO_N; k++) begin : g_gpo
        if (k == WAIT_IX) begin : g_shared
            assign gpo_lo[k] = running && !cfg_wait_en && w_lo[k];
            assign gpo_hi[k] = running && !cfg_wait_en && w_hi[k];
        end else begin : g_plain
            assign gpo_lo[k] = running && w_lo[k];
            assign gpo_hi[k] = running && w_hi[k];
        end
    end
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int LOOP_W = 4,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        w_redo,
    input  logic              w_loop,
    input  logic              w_step,
    input  logic              w_ack,
    input  logic              w_last,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [BEAT_W-1:0] req_addr,
    input  logic              ref_req,
    input  logic              exc_req,
    input  logic              stall,
    input  logic [LOOP_W-1:0] rd_loop,
    input  logic [LOOP_W-1:0] wr_loop,
    output logic [ADDR_W-1:0] pc,
    output logic              running,
    output logic              ta,
    output logic [BEAT_W-1:0] beat_addr
);
    localparam logic [ADDR_W-1:0] PC_ONE   = 1;
    localparam logic [BEAT_W-1:0] BEAT_ONE = 1;
    localparam logic [LOOP_W-1:0] PASS_ONE = 1;
    localparam logic [1:0]        REDO_ONE = 1;

    typedef struct packed {
        logic              run;
        logic              is_wr;
        logic [ADDR_W-1:0] pc;
        logic [1:0]        redo;
        logic              in_loop;
        logic [ADDR_W-1:0] loop_pc;
        logic [LOOP_W-1:0] pass;
        logic [BEAT_W-1:0] beat;
    } seq_state_t;

    seq_state_t q, d;
    logic       ack_d;

    always_comb begin
        logic              final_cyc;
        logic [LOOP_W-1:0] limit;
        d         = q;
        ack_d     = 1'b0;
        final_cyc = (q.redo == w_redo);
        limit     = q.is_wr ? wr_loop : rd_loop;
        if (!q.run) begin
            d.redo    = '0;
            d.in_loop = 1'b0;
            d.pass    = '0;
            if (exc_req) begin
                d.run = 1'b1; d.is_wr = 1'b0; d.pc = ENT_EXC; d.beat = '0;
            end else if (ref_req) begin
                d.run = 1'b1; d.is_wr = 1'b0; d.pc = ENT_REF; d.beat = '0;
            end else if (req_valid) begin
                d.run   = 1'b1;
                d.is_wr = req_write;
                d.beat  = req_addr;
                if (req_write) d.pc = req_burst ? ENT_BWR : ENT_SWR;
                else           d.pc = req_burst ? ENT_BRD : ENT_SRD;
            end
        end else if (!stall) begin
            if (!final_cyc) begin
                d.redo = q.redo + REDO_ONE;
            end else begin
                d.redo = '0;
                ack_d  = w_ack;
                if (w_step) d.beat = q.beat + BEAT_ONE;
                if (w_last) begin
                    d.run = 1'b0;
                end else if (w_loop && !q.in_loop) begin
                    d.in_loop = 1'b1;
                    d.loop_pc = q.pc;
                    d.pass    = '0;
                    d.pc      = q.pc + PC_ONE;
                end else if (w_loop && q.pc != q.loop_pc) begin
                    if (q.pass < limit) begin
                        d.pass = q.pass + PASS_ONE;
                        d.pc   = q.loop_pc;
                    end else begin
                        d.in_loop = 1'b0;
                        d.pc      = q.pc + PC_ONE;
                    end
                end else begin
                    d.pc = q.pc + PC_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pc        = q.pc;
    assign running   = q.run;
    assign ta        = ack_d;
    assign beat_addr = q.beat;
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int LOOP_W = 4,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [BEAT_W-1:0] req_addr,
    input  logic              ref_req,
    input  logic              exc_req,
    input  logic [LOOP_W-1:0] cfg_rd_loop,
    input  logic [LOOP_W-1:0] cfg_wr_loop,
    input  logic              cfg_wait_en,
    input  logic              cfg_wait_pol,
    input  logic              wait_in,
    output logic [3:0]        cs_ph,
    output logic [3:0]        bs_ph,
    output logic [4:0]        gpo_lo,
    output logic [4:0]        gpo_hi,
    output logic              ta,
    output logic              busy,
    output logic [BEAT_W-1:0] beat_addr
);
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] raw;
    ctl_word_t         w;
    logic              running, stall;

    assign w    = ctl_word_t'(raw);
    assign busy = running;

    useq_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_wdata),
        .raddr(pc), .rdata(raw)
    );

    useq_core #(.LOOP_W(LOOP_W), .BEAT_W(BEAT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .w_redo(w.redo), .w_loop(w.loop), .w_step(w.step), .w_ack(w.ack), .w_last(w.last),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .ref_req(ref_req), .exc_req(exc_req), .stall(stall),
        .rd_loop(cfg_rd_loop), .wr_loop(cfg_wr_loop),
        .pc(pc), .running(running), .ta(ta), .beat_addr(beat_addr)
    );

    useq_pinmux #(.GPO_N(5), .WAIT_IX(3)) u_pins (
        .running(running), .w_cs(w.cs), .w_bs(w.bs), .w_lo(w.gpo_lo), .w_hi(w.gpo_hi),
        .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol), .wait_in(wait_in),
        .stall(stall), .cs_ph(cs_ph), .bs_ph(bs_ph), .gpo_lo(gpo_lo), .gpo_hi(gpo_hi)
    );
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int BEAT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ta,
    input logic [3:0]        cs_ph,
    input logic [3:0]        bs_ph,
    input logic [4:0]        gpo_lo,
    input logic [4:0]        gpo_hi,
    input logic [BEAT_W-1:0] beat_addr,
    input logic              cfg_wait_en,
    input logic              cfg_wait_pol,
    input logic              wait_in
);
    // R2
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_ph == 4'hF && bs_ph == 4'hF && gpo_lo == 5'd0 && !ta));

    // R7
    ack_in_routine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta |-> busy);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wait_en && wait_in == cfg_wait_pol)
            |=> (busy && $stable(cs_ph) && $stable(bs_ph) && $stable(beat_addr)));

    // R9
    stall_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait_en && wait_in == cfg_wait_pol) |-> !ta);

    // R10
    shared_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wait_en |-> (!gpo_lo[3] && !gpo_hi[3]));

    // R6
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && beat_addr != $past(beat_addr))
            |-> (beat_addr == $past(beat_addr) + 5'd1));
endmodule

bind useq_top useq_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ta(ta), .cs_ph(cs_ph), .bs_ph(bs_ph),
    .gpo_lo(gpo_lo), .gpo_hi(gpo_hi), .beat_addr(beat_addr),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol), .wait_in(wait_in)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [23:0] prog_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [4:0]  req_addr = '0;
    logic        ref_req = 1'b0, exc_req = 1'b0;
    logic [3:0]  cfg_rd_loop = '0, cfg_wr_loop = '0;
    logic        cfg_wait_en = 1'b0, cfg_wait_pol = 1'b1, wait_in = 1'b0;
    logic [3:0]  cs_ph, bs_ph;
    logic [4:0]  gpo_lo, gpo_hi, beat_addr;
    logic        ta, busy;

    int vectors = 0, miscompares = 0;
    logic [3:0] trace [0:255];
    int len, tas;
    logic [3:0] f_bs;
    logic [4:0] f_lo, f_hi;

    always #2 clk = ~clk;

    useq_top dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic [3:0] cs, input logic [3:0] bs,
                                       input logic [4:0] lo, input logic [4:0] hi,
                                       input logic [1:0] redo, input logic lp,
                                       input logic st, input logic ak, input logic ls);
        return {ls, ak, st, lp, redo, hi, lo, bs, cs};
    endfunction

    task automatic prog(input int a, input logic [23:0] d);
        @(posedge clk); #1;
        prog_we = 1'b1; prog_addr = 6'(a); prog_wdata = d;
        @(posedge clk); #1;
        prog_we = 1'b0;
    endtask

    task automatic launch(input logic v, input logic w, input logic b, input logic [4:0] a,
                          input logic rf, input logic ex);
        @(posedge clk); #1;
        req_valid = v; req_write = w; req_burst = b; req_addr = a; ref_req = rf; exc_req = ex;
        @(posedge clk); #1;
        req_valid = 1'b0; ref_req = 1'b0; exc_req = 1'b0;
    endtask

    // poke_at: cycle index inside the routine at which request pulses are fired
    task automatic collect(input int stall_k, input logic pol, input int poke_at);
        len = 0; tas = 0;
        while (busy && len < 256) begin
            wait_in   = (len < stall_k) ? pol : ~pol;
            ref_req   = (len == poke_at);
            req_valid = (len == poke_at);
            exc_req   = (len == poke_at);
            #1;
            trace[len] = cs_ph;
            if (len == 0) begin f_bs = bs_ph; f_lo = gpo_lo; f_hi = gpo_hi; end
            if (ta) tas++;
            len++;
            @(posedge clk); #1;
        end
        ref_req = 1'b0; req_valid = 1'b0; exc_req = 1'b0; wait_in = ~pol;
    endtask

    task automatic check_loop(input string tag, input int n, input int start);
        int ok;
        ok = (len > 0) ? 1 : 0;
        for (int i = 0; i < len - 1; i++) if (trace[i] != 4'(4 + (i % 3))) ok = 0;
        if (len > 0 && trace[len-1] != 4'd7) ok = 0;
        chk({tag, " R5 trace length"}, len, 3 * (n + 1) + 1);
        chk({tag, " R5 body pattern"}, ok, 1);
        chk({tag, " R7 acknowledge count"}, tas, n + 1);
        chk({tag, " R6 beat address wrap"}, beat_addr, (start + n + 1) % 32);
        chk({tag, " R8 idle after last"}, busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R2 reset cs", cs_ph, 15);
        chk("R2 reset bs", bs_ph, 15);
        chk("R2 reset gpo", {gpo_hi, gpo_lo}, 0);
        chk("R8 reset busy", busy, 0);
        chk("R7 reset ta", ta, 0);

        prog(8'h00, mk(4'h1, 4'hE, 5'h03, 5'h1C, 2'd2, 0, 0, 0, 0));
        prog(8'h01, mk(4'h2, 4'h0, 5'h00, 5'h00, 2'd0, 0, 1, 1, 0));
        prog(8'h02, mk(4'h3, 4'h0, 5'h00, 5'h00, 2'd0, 0, 0, 0, 1));
        for (int b = 0; b < 2; b++) begin
            int base;
            base = (b == 0) ? 8'h08 : 8'h20;
            prog(base + 0, mk(4'h4, 4'h0, 5'h0, 5'h0, 2'd0, 1, 0, 0, 0));
            prog(base + 1, mk(4'h5, 4'h0, 5'h0, 5'h0, 2'd0, 0, 1, 1, 0));
            prog(base + 2, mk(4'h6, 4'h0, 5'h0, 5'h0, 2'd0, 1, 0, 0, 0));
            prog(base + 3, mk(4'h7, 4'h0, 5'h0, 5'h0, 2'd0, 0, 0, 0, 1));
        end
        prog(8'h18, mk(4'h8, 4'h3, 5'h1D, 5'h0A, 2'd0, 0, 0, 0, 0));
        prog(8'h19, mk(4'h9, 4'h0, 5'h00, 5'h00, 2'd0, 0, 0, 1, 1));
        prog(8'h30, mk(4'hA, 4'h0, 5'h00, 5'h00, 2'd0, 0, 0, 0, 1));
        prog(8'h3C, mk(4'hB, 4'h0, 5'h00, 5'h00, 2'd0, 0, 0, 0, 1));

        // single read: redo, ack, step, last
        launch(1, 0, 0, 5'd7, 0, 0);
        collect(0, 1, -1);
        chk("R1 single read entry", trace[0], 1);
        chk("R4 redo length", len, 5);
        chk("R4 redo third copy", trace[2], 1);
        chk("R2 word after redo", trace[3], 2);
        chk("R2 bs quarter phases", f_bs, 14);
        chk("R3 gpo phases 1-2", f_lo, 3);
        chk("R3 gpo phases 3-4", f_hi, 28);
        chk("R7 single ack", tas, 1);
        chk("R6 beat load and step", beat_addr, 8);
        chk("R8 idle after last", busy, 0);

        // burst read loop sweep, write count held at 3
        cfg_wr_loop = 4'd3;
        for (int n = 0; n < 4; n++) begin
            cfg_rd_loop = 4'(n);
            launch(1, 0, 1, 5'd30, 0, 0);
            collect(0, 1, -1);
            check_loop("R1 burst read", n, 30);
        end
        // burst write loop sweep, read count held at 3
        cfg_rd_loop = 4'd3;
        for (int n = 0; n < 4; n++) begin
            cfg_wr_loop = 4'(n);
            launch(1, 1, 1, 5'd29, 0, 0);
            collect(0, 1, -1);
            check_loop("R1 burst write", n, 29);
        end

        // single write with wait disabled: wait_in has no effect, gpo4 driven
        cfg_wait_en = 1'b0;
        launch(1, 1, 0, 5'd0, 0, 0);
        collect(5, 1, -1);
        chk("R9 wait ignored when disabled", len, 2);
        chk("R1 single write entry", trace[0], 8);
        chk("R3 gpo4 driven lo", f_lo, 29);
        chk("R3 gpo4 driven hi", f_hi, 10);

        // stall sweep, both polarities
        cfg_wait_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cfg_wait_pol = p[0];
            wait_in = ~p[0];
            for (int k = 0; k < 5; k++) begin
                launch(1, 1, 0, 5'd0, 0, 0);
                collect(k, p[0], -1);
                chk("R9 stall length", len, 2 + k);
                chk("R9 held word", trace[k], 8);
                chk("R7 no ack in stall", tas, 1);
                chk("R10 gpo4 released lo", f_lo, 21);
                chk("R10 gpo4 released hi", f_hi, 2);
            end
        end
        cfg_wait_en = 1'b0;
        wait_in = 1'b0;

        // refresh alone, refresh beating an access, exception beating both
        launch(0, 0, 0, 5'd3, 1, 0);
        collect(0, 1, -1);
        chk("R1 refresh entry", trace[0], 10);
        chk("R6 refresh beat zero", beat_addr, 0);
        launch(1, 0, 0, 5'd3, 1, 0);
        collect(0, 1, -1);
        chk("R11 refresh over access", trace[0], 10);
        chk("R11 access dropped", len, 1);
        launch(1, 1, 1, 5'd3, 1, 1);
        collect(0, 1, -1);
        chk("R11 exception first", trace[0], 11);
        chk("R11 exception length", len, 1);
        #2;
        chk("R11 losers dropped", busy, 0);

        // pulses during a routine are ignored
        launch(1, 0, 0, 5'd1, 0, 0);
        collect(0, 1, 1);
        chk("R12 routine unaffected", len, 5);
        @(posedge clk); #1;
        chk("R12 nothing follows", busy, 0);

        // host port rewrite of the refresh word
        prog(8'h30, mk(4'hC, 4'h5, 5'h00, 5'h00, 2'd0, 0, 0, 0, 1));
        launch(0, 0, 0, 5'd0, 1, 0);
        collect(0, 1, -1);
        chk("R13 rewritten cs", trace[0], 12);
        chk("R13 rewritten bs", f_bs, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule